// File: doc/BRIEF.md
# Backlight Intensity Controller

This block converts a requested backlight level into a single write toward the panel's duty register, plus two pin levels and a notification pulse. A system controller presents a 6-bit level. It qualifies the level with a suspend flag, a low-battery flag and a clamp limit. It then either pulses an update strobe or changes one of the flags.

On each update the block applies the overrides in a fixed order. Suspend wins first, and the low-battery clamp applies after it. Next the block moves the value out of the band just above 16. It then registers the final value. In that same cycle it raises the write request, drives the enable and high-range pins, and pulses the battery-monitor output. The register holds the final value until the next update.

Top module: `bl_intensity_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, duty_wr_o, bl_en_o, bl_hi_o, batt_kick_o and applied_o are all 0 until the first update.
- R2: When suspend_i is 1 at an update, the applied value is 0, whatever the level, battery flag or limit.
- R3: When batt_low_i is 1 and suspend_i is 0, a level above limit_i is replaced by limit_i. A level at or below limit_i is kept.
- R4: After the overrides, a value above 16 has 16 added to it. A value of 16 or less is unchanged, so applied_o never takes a value from 17 to 32.
- R5: An update is registered on the clock edge that samples it. duty_wr_o is then 1 for exactly one cycle, and duty_data_o carries bits 4:0 of the applied value. duty_addr_o is constant 2.
- R6: bl_hi_o equals bit 5 of the applied value.
- R7: bl_en_o is 1 exactly when the applied value is nonzero.
- R8: batt_kick_o pulses for one cycle together with each write. applied_o shows the value of the most recent update.
- R9: A change of suspend_i or batt_low_i, with update_i low, starts an update using the current level and limit.
- R10: Without update_i and without a flag change, a change of level_i or limit_i has no effect. No write occurs and every output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_i | input | 6 | Requested intensity |
| suspend_i | input | 1 | Forces intensity to zero |
| batt_low_i | input | 1 | Enables clamp to limit_i |
| limit_i | input | 6 | Clamp ceiling under low battery |
| update_i | input | 1 | Update strobe |
| duty_wr_o | output | 1 | One-cycle duty register write request |
| duty_addr_o | output | 3 | Duty register address (2) |
| duty_data_o | output | 5 | Low 5 bits of applied value |
| bl_en_o | output | 1 | Backlight enable pin |
| bl_hi_o | output | 1 | High-range control pin |
| batt_kick_o | output | 1 | Pulse to battery monitor |
| applied_o | output | 7 | Applied intensity |

## Verification
Each output depends on a single register stage. A wrong override order or a wrong remap therefore appears at the ports one edge after the update: on applied_o, on the duty data, and on the two pin levels. A faulty flag-change detector shows up in one of two ways. Either a write is missing in the cycle after a bare flag toggle, or a spurious write appears in the quiet cycle after an update. The bench checks both directly.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int unsigned LVL_W     = 6;
  localparam int unsigned APP_W     = LVL_W + 1;
  localparam int unsigned DUTY_W    = 5;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned DUTY_ADDR = 2;
  localparam int unsigned GAP_BASE  = 16;
  localparam int unsigned HI_BIT    = 5;
endpackage

// File: rtl/bl_override.sv
module bl_override #(
  parameter int unsigned LVL_W = bl_pkg::LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] limit_i,
  input  logic             suspend_i,
  input  logic             batt_low_i,
  output logic [LVL_W-1:0] eff_o
);
  // suspend outranks the battery clamp
  always_comb begin
    if (suspend_i)                          eff_o = '0;
    else if (batt_low_i && level_i > limit_i) eff_o = limit_i;
    else                                    eff_o = level_i;
  end

  p_clamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (batt_low_i && !suspend_i) |-> (eff_o <= limit_i));
  p_susp_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i |-> (eff_o == '0));
endmodule

// File: rtl/bl_remap.sv
module bl_remap #(
  parameter int unsigned LVL_W    = bl_pkg::LVL_W,
  parameter int unsigned APP_W    = bl_pkg::APP_W,
  parameter int unsigned GAP_BASE = bl_pkg::GAP_BASE
) (
  input  logic [LVL_W-1:0] eff_i,
  output logic [APP_W-1:0] val_o
);
  localparam logic [APP_W-1:0] GAP = APP_W'(GAP_BASE);
  logic [APP_W-1:0] wide;
  assign wide  = {{(APP_W-LVL_W){1'b0}}, eff_i};
  // skip codes GAP+1 .. 2*GAP
  assign val_o = (wide > GAP) ? wide + GAP : wide;

  always_comb begin
    a_no_gap_r4: assert (!(val_o > GAP && val_o <= GAP + GAP));
  end
endmodule

// File: rtl/bl_out_reg.sv
module bl_out_reg #(
  parameter int unsigned APP_W  = bl_pkg::APP_W,
  parameter int unsigned HI_BIT = bl_pkg::HI_BIT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [APP_W-1:0] val_i,
  output logic             wr_o,
  output logic             kick_o,
  output logic             en_o,
  output logic             hi_o,
  output logic [APP_W-1:0] app_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o   <= 1'b0;
      kick_o <= 1'b0;
      en_o   <= 1'b0;
      hi_o   <= 1'b0;
      app_o  <= '0;
    end else begin
      wr_o   <= trig_i;
      kick_o <= trig_i;
      if (trig_i) begin
        app_o <= val_i;
        en_o  <= |val_i;
        hi_o  <= val_i[HI_BIT];
      end
    end
  end

  p_en_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o == (app_o != '0));
  p_hi_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_o == app_o[HI_BIT]);
  p_kick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (kick_o && wr_o));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> (!wr_o && $stable(app_o)));
endmodule

// File: rtl/bl_intensity_ctrl.sv
module bl_intensity_ctrl #(
  parameter int unsigned LVL_W     = bl_pkg::LVL_W,
  parameter int unsigned DUTY_W    = bl_pkg::DUTY_W,
  parameter int unsigned ADDR_W    = bl_pkg::ADDR_W,
  parameter int unsigned DUTY_ADDR = bl_pkg::DUTY_ADDR,
  parameter int unsigned GAP_BASE  = bl_pkg::GAP_BASE,
  parameter int unsigned HI_BIT    = bl_pkg::HI_BIT
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LVL_W-1:0]     level_i,
  input  logic                 suspend_i,
  input  logic                 batt_low_i,
  input  logic [LVL_W-1:0]     limit_i,
  input  logic                 update_i,
  output logic                 duty_wr_o,
  output logic [ADDR_W-1:0]    duty_addr_o,
  output logic [DUTY_W-1:0]    duty_data_o,
  output logic                 bl_en_o,
  output logic                 bl_hi_o,
  output logic                 batt_kick_o,
  output logic [LVL_W:0]       applied_o
);
  localparam int unsigned APP_W = LVL_W + 1;

  logic             susp_q, low_q, trig;
  logic [LVL_W-1:0] eff;
  logic [APP_W-1:0] val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      susp_q <= 1'b0;
      low_q  <= 1'b0;
    end else begin
      susp_q <= suspend_i;
      low_q  <= batt_low_i;
    end
  end

  // flag edges re-run the update
  assign trig = update_i | (suspend_i ^ susp_q) | (batt_low_i ^ low_q);

  bl_override #(.LVL_W(LVL_W)) u_ovr (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level_i), .limit_i(limit_i),
    .suspend_i(suspend_i), .batt_low_i(batt_low_i), .eff_o(eff));

  bl_remap #(.LVL_W(LVL_W), .APP_W(APP_W), .GAP_BASE(GAP_BASE)) u_map (
    .eff_i(eff), .val_o(val));

  bl_out_reg #(.APP_W(APP_W), .HI_BIT(HI_BIT)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig), .val_i(val),
    .wr_o(duty_wr_o), .kick_o(batt_kick_o), .en_o(bl_en_o),
    .hi_o(bl_hi_o), .app_o(applied_o));

  assign duty_addr_o = ADDR_W'(DUTY_ADDR);
  assign duty_data_o = applied_o[DUTY_W-1:0];

  p_susp_applied_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_wr_o && $past(suspend_i)) |-> (applied_o == '0));
  p_flag_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_i != susp_q) |=> duty_wr_o);
endmodule

// File: tb/bl_intensity_ctrl_tb_top.sv
module bl_intensity_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] level = '0, limit = '0;
  logic       susp = 1'b0, low = 1'b0, upd = 1'b0;
  logic       wr, en, hi, kick;
  logic [2:0] addr;
  logic [4:0] data;
  logic [6:0] app;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bl_intensity_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .level_i(level), .suspend_i(susp),
    .batt_low_i(low), .limit_i(limit), .update_i(upd),
    .duty_wr_o(wr), .duty_addr_o(addr), .duty_data_o(data),
    .bl_en_o(en), .bl_hi_o(hi), .batt_kick_o(kick), .applied_o(app));

  function automatic logic [6:0] model(logic [5:0] l, logic s, logic b, logic [5:0] m);
    logic [6:0] e;
    e = s ? 7'd0 : ((b && l > m) ? {1'b0, m} : {1'b0, l});
    return (e > 7'd16) ? e + 7'd16 : e;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_write(string req, logic [6:0] exp);
    chk({req, " R5 wr"}, wr, 1);
    chk({req, " R5 addr"}, addr, 2);
    chk({req, " R5 data"}, data, exp[4:0]);
    chk({req, " R6 hi"}, hi, exp[5]);
    chk({req, " R7 en"}, en, exp != 0);
    chk({req, " R8 kick"}, kick, 1);
    chk({req, " R8 applied"}, app, exp);
  endtask

  task automatic check_quiet(string req, logic [6:0] exp);
    chk({req, " R10 wr"}, wr, 0);
    chk({req, " R8 kick"}, kick, 0);
    chk({req, " R10 applied"}, app, exp);
  endtask

  // strobed update with given inputs; checks the write and the following idle cycle
  task automatic do_update(string req, logic [5:0] l, logic s, logic b, logic [5:0] m);
    logic [6:0] exp;
    exp = model(l, s, b, m);
    @(negedge clk);
    level = l; susp = s; low = b; limit = m; upd = 1'b1;
    @(posedge clk); #1;
    check_write(req, exp);
    @(negedge clk); upd = 1'b0;
    @(posedge clk); #1;
    check_quiet(req, exp);
  endtask

  task automatic t_reset;
    chk("R1 wr", wr, 0); chk("R1 en", en, 0); chk("R1 hi", hi, 0);
    chk("R1 kick", kick, 0); chk("R1 applied", app, 0);
  endtask

  task automatic t_remap;
    do_update("R4 zero", 6'd0, 0, 0, 6'd0);
    do_update("R4 one", 6'd1, 0, 0, 6'd0);
    do_update("R4 sixteen", 6'd16, 0, 0, 6'd0);
    do_update("R4 seventeen", 6'd17, 0, 0, 6'd0);
    do_update("R4 32", 6'd32, 0, 0, 6'd0);
    do_update("R6 47", 6'd47, 0, 0, 6'd0);
    do_update("R6 63", 6'd63, 0, 0, 6'd0);
  endtask

  task automatic t_overrides;
    do_update("R3 clamp", 6'd50, 0, 1, 6'd20);
    do_update("R3 below", 6'd10, 0, 1, 6'd20);
    do_update("R3 equal", 6'd20, 0, 1, 6'd20);
    do_update("R2 suspend", 6'd63, 1, 1, 6'd20);
    do_update("R2 susp only", 6'd40, 1, 0, 6'd0);
  endtask

  task automatic t_flag_edges;
    do_update("R9 base", 6'd40, 0, 0, 6'd12);
    @(negedge clk); susp = 1'b1;
    @(posedge clk); #1; check_write("R9 susp rise", 7'd0);
    @(posedge clk); #1; check_quiet("R9 susp rise", 7'd0);
    @(negedge clk); susp = 1'b0;
    @(posedge clk); #1; check_write("R9 susp fall", model(6'd40, 0, 0, 6'd12));
    @(negedge clk); low = 1'b1;
    @(posedge clk); #1; check_write("R9 low rise", model(6'd40, 0, 1, 6'd12));
    @(posedge clk); #1; check_quiet("R9 low rise", model(6'd40, 0, 1, 6'd12));
  endtask

  task automatic t_ignore;
    logic [6:0] held;
    held = app;
    @(negedge clk); level = 6'd5; limit = 6'd60;
    @(posedge clk); #1; check_quiet("R10 level chg", held);
    @(posedge clk); #1; check_quiet("R10 later", held);
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1; t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1; t_reset();
    t_remap();
    t_overrides();
    t_flag_edges();
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule